// File: doc/BRIEF.md
# DMA Transfer Bus Cycle Sequencer

This block runs the external bus cycles of one DMA channel once the bus has been handed to it. A one-clock `start` launches a transfer. The sizes, addresses and mode are latched at that edge. In dual address mode the block makes an indivisible pair: it reads from the source, holds the data, and then writes it to the destination. In single address mode it makes only the memory-side cycle. The device-side acknowledge (`dack_n`) then strobes the external device directly. In the read direction `dack_n` is the device's write strobe. In the write direction it is the device's read strobe.

The top address bits select one of several areas. Each area is set up as 8 or 16 bits wide and as 2 or 3 states per access. A word moved over an 8-bit area takes two byte cycles, high byte first, with the byte address stepping by one. Addresses at or above a fixed internal base are on-chip. They take two states at full width and leave the external strobes and address bus idle. A single-address request that points into that space is refused with an error pulse.

Top module: `dma_bus_seq`

## Requirements
- R1: In dual address mode every read cycle comes before every write cycle. `busy` stays high without a break from the first read state to the last write state. The read data (latched at the end of the last read state) is what the write cycles drive.
- R2: An access to area `a` (area = `addr[AW-1 -: AREA_BITS]`) lasts 3 states when `area_3st[a]` is 1 and 2 states otherwise. The address is held for the whole cycle. `as_n`, `rd_n`, `hwr_n`, `lwr_n` and `dack_n` are low only from the second state to the last.
- R3: When `area_wide[a]` is 1, a word moves in one cycle on `data[15:0]`, and a word write drives `hwr_n` and `lwr_n` together. When `area_wide[a]` is 0, a word moves in two cycles on `data[7:0]` using only `lwr_n`. The high byte comes first at the base address and the low byte follows at the base address plus 1.
- R4: A byte access to a 16-bit area uses address bit 0 to pick the lane. Even uses `data[15:8]` and `hwr_n`. Odd uses `data[7:0]` and `lwr_n`. Byte write data is driven on both lanes.
- R5: In single address read mode (`single`=1, `wr_dir`=0) only memory read cycles are made, at `src_addr`. `dack_n` is low in exactly the states where `as_n` is low, and no write strobe is asserted.
- R6: In single address write mode (`single`=1, `wr_dir`=1) only memory write cycles are made, at `dst_addr`. `dack_n` is low exactly with `as_n`, and `rd_n` stays high.
- R7: An address at or above `INT_BASE` is an on-chip access. It lasts 2 states at 16-bit width, keeps `addr` at zero and keeps every strobe high. Its read data is still taken from `in_data`.
- R8: A start in single address mode whose memory address is at or above `INT_BASE` gives a one-clock `err` pulse. No `busy` follows and no strobe is asserted.
- R9: `busy` rises the clock after an accepted `start` and falls after the last state of the final cycle. `done` is high for one clock just after that. A `start` while `busy` is high is ignored.
- R10: While `rst_n` is low and after its release, all strobes are high, `addr` is zero and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Bus granted; begin a transfer |
| single | input | 1 | 1 = single address mode, 0 = dual |
| wr_dir | input | 1 | Single mode: 1 = device to memory, 0 = memory to device |
| word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| src_addr | input | AW | Source address (memory address in single read) |
| dst_addr | input | AW | Destination address (memory address in single write) |
| area_wide | input | NAREA | Per area: 1 = 16-bit bus, 0 = 8-bit |
| area_3st | input | NAREA | Per area: 1 = 3 states, 0 = 2 states |
| in_data | input | 16 | Read data |
| addr | output | AW | External address bus |
| out_data | output | 16 | Write data |
| as_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| hwr_n | output | 1 | High-lane write strobe, active low |
| lwr_n | output | 1 | Low-lane write strobe, active low |
| dack_n | output | 1 | Device acknowledge strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| err | output | 1 | One-clock refused-request pulse |

## Verification
The assertions assume that `start` comes only as a one-clock pulse. They also assume the area settings stay fixed while a transfer runs, and that a word address on a 16-bit area is even. The bench drives every input on the falling clock edge, so these stay put across each active edge. It changes the area setup only between transfers, gives word transfers on wide areas even addresses, and keeps the byte after a narrow-area word address out of internal space.

// File: rtl/dma_bus_seq.sv
module dma_bus_seq #(
  parameter int AW        = 24,
  parameter int AREA_BITS = 3,
  parameter logic [AW-1:0] INT_BASE = 24'hFF0000,
  localparam int NAREA    = 1 << AREA_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             single,
  input  logic             wr_dir,
  input  logic             word,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic [NAREA-1:0] area_wide,
  input  logic [NAREA-1:0] area_3st,
  input  logic [15:0]      in_data,
  output logic [AW-1:0]    addr,
  output logic [15:0]      out_data,
  output logic             as_n,
  output logic             rd_n,
  output logic             hwr_n,
  output logic             lwr_n,
  output logic             dack_n,
  output logic             busy,
  output logic             done,
  output logic             err
);

  logic          run, phase, beat, done_q, err_q;
  logic [1:0]    tcnt;
  logic          r_single, r_word;
  logic [AW-1:0] r_src, r_dst;
  logic [15:0]   dreg;

  wire [AW-1:0]        base      = phase ? r_dst : r_src;
  wire [AW-1:0]        cur       = base + AW'(beat);
  wire                 internal  = cur >= INT_BASE;
  wire [AREA_BITS-1:0] area      = cur[AW-1 -: AREA_BITS];
  wire                 wide      = internal | area_wide[area];
  wire [1:0]           last_t    = (!internal && area_3st[area]) ? 2'd2 : 2'd1;
  wire                 two_beats = r_word & ~wide;
  wire                 cyc_end   = run && (tcnt == last_t);
  wire                 final_cyc = (beat == two_beats) && (r_single || phase);
  wire                 strobe    = run && (tcnt != 2'd0) && !internal;
  wire                 hi_lane   = wide && (r_word || !cur[0]);
  wire                 lo_lane   = !wide || r_word || cur[0];
  wire [AW-1:0]        s_mem     = wr_dir ? dst_addr : src_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; phase <= 1'b0; beat <= 1'b0; tcnt <= 2'd0;
      done_q <= 1'b0; err_q <= 1'b0;
      r_single <= 1'b0; r_word <= 1'b0;
      r_src <= '0; r_dst <= '0; dreg <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!run) begin
        if (start) begin
          if (single && s_mem >= INT_BASE) err_q <= 1'b1;
          else begin
            run <= 1'b1; phase <= single & wr_dir; beat <= 1'b0; tcnt <= 2'd0;
            r_single <= single; r_word <= word;
            r_src <= src_addr; r_dst <= dst_addr;
          end
        end
      end else if (cyc_end) begin
        tcnt <= 2'd0;
        if (!phase) begin
          if (wide) begin
            if (r_word) dreg <= in_data;
            else        dreg[7:0] <= cur[0] ? in_data[7:0] : in_data[15:8];
          end else if (r_word && !beat) dreg[15:8] <= in_data[7:0];
          else                          dreg[7:0]  <= in_data[7:0];
        end
        if (beat != two_beats) beat <= 1'b1;
        else if (final_cyc) begin
          run <= 1'b0; done_q <= 1'b1;
        end else begin
          phase <= 1'b1; beat <= 1'b0;
        end
      end else begin
        tcnt <= tcnt + 2'd1;
      end
    end
  end

  assign addr     = (run && !internal) ? cur : '0;
  assign as_n     = !strobe;
  assign rd_n     = !(strobe && !phase);
  assign hwr_n    = !(strobe && phase && hi_lane);
  assign lwr_n    = !(strobe && phase && lo_lane);
  assign dack_n   = !(strobe && r_single);
  assign out_data = wide ? (r_word ? dreg : {dreg[7:0], dreg[7:0]})
                         : {8'h00, (r_word && !beat) ? dreg[15:8] : dreg[7:0]};
  assign busy     = run;
  assign done     = done_q;
  assign err      = err_q;

  p_no_rd_wr_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (hwr_n && lwr_n));
  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tcnt != 2'd0) |-> $stable(addr));
  p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> busy);
  p_dack_with_as_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_n |-> !as_n);
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && as_n));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/dma_bus_seq_bench.sv
module dma_bus_seq_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, single = 0, wr_dir = 0, word = 0;
  logic [23:0] src_addr = 0, dst_addr = 0, addr;
  logic [7:0]  area_wide = 8'b0000_0101, area_3st = 8'b0000_0010;
  logic [15:0] in_data = 0, out_data;
  logic as_n, rd_n, hwr_n, lwr_n, dack_n, busy, done, err;

  int checks = 0, fails = 0;
  int nbusy, nrd, nhw, nlw, ndk, nas, ndone, nerr, dkmis, rdafterwr, gap, firstb, lastb;
  logic [23:0] fwa, lwa, frda, lrda, a0, a1;
  logic [15:0] fwd, lwd;

  always #(PERIOD/2) clk = ~clk;

  dma_bus_seq u_dma_bus_seq (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic s, input logic w, input logic wd,
                     input logic [23:0] sa, input logic [23:0] da,
                     input logic [15:0] din, input bit restart);
    logic seen_w;
    @(negedge clk);
    single = s; wr_dir = w; word = wd; src_addr = sa; dst_addr = da; in_data = din; start = 1;
    nbusy = 0; nrd = 0; nhw = 0; nlw = 0; ndk = 0; nas = 0; ndone = 0; nerr = 0;
    dkmis = 0; rdafterwr = 0; firstb = -1; lastb = -1; seen_w = 0;
    fwa = 0; lwa = 0; frda = 0; lrda = 0; fwd = 0; lwd = 0; a0 = 0; a1 = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 20; i++) begin
      if (restart && i == 1) begin src_addr = 24'h000700; dst_addr = 24'h400700; start = 1; end
      if (restart && i == 2) start = 0;
      if (i == 0) a0 = addr;
      if (i == 1) a1 = addr;
      if (busy) begin nbusy++; if (firstb < 0) firstb = i; lastb = i; end
      if (done) ndone++;
      if (err) nerr++;
      if (!as_n) nas++;
      if (!dack_n) ndk++;
      if (single && (dack_n != as_n)) dkmis++;
      if (!rd_n) begin
        nrd++; if (seen_w) rdafterwr++;
        if (nrd == 1) frda = addr;
        lrda = addr;
      end
      if (!hwr_n) nhw++;
      if (!lwr_n) nlw++;
      if (!hwr_n || !lwr_n) begin
        if (!seen_w) begin fwa = addr; fwd = out_data; end
        seen_w = 1; lwa = addr; lwd = out_data;
      end
      @(negedge clk);
    end
    gap = (nbusy > 0) ? (lastb - firstb + 1 - nbusy) : 0;
  endtask

  task automatic t_reset;
    chk("R10", "as_n", as_n, 1); chk("R10", "rd_n", rd_n, 1);
    chk("R10", "wr strobes", {hwr_n, lwr_n}, 2'b11); chk("R10", "dack_n", dack_n, 1);
    chk("R10", "busy/done/err", {busy, done, err}, 3'b000); chk("R10", "addr", addr, 0);
  endtask

  task automatic t_dual_wide_to_narrow;
    run(0, 0, 1, 24'h000100, 24'h200200, 16'hA55A, 0);
    chk("R2", "busy states 2+3+3", nbusy, 8);
    chk("R1", "busy continuous", gap, 0);
    chk("R1", "read before write", rdafterwr, 0);
    chk("R1", "read addr", frda, 24'h000100);
    chk("R2", "rd low states", nrd, 1);
    chk("R3", "narrow lwr states", nlw, 4);
    chk("R3", "narrow no hwr", nhw, 0);
    chk("R3", "first byte addr", fwa, 24'h200200);
    chk("R3", "second byte addr", lwa, 24'h200201);
    chk("R3", "high byte first", fwd[7:0], 8'hA5);
    chk("R3", "low byte second", lwd[7:0], 8'h5A);
    chk("R9", "one done", ndone, 1);
    chk("R9", "done after busy", lastb + 1 >= 0 ? nbusy : 0, 8);
  endtask

  task automatic t_dual_wide_to_wide;
    run(0, 0, 1, 24'h000100, 24'h400010, 16'hA55A, 0);
    chk("R3", "wide busy", nbusy, 4);
    chk("R3", "wide both strobes", {nhw[3:0], nlw[3:0]}, 8'h11);
    chk("R1", "word data", fwd, 16'hA55A);
    chk("R1", "write addr", fwa, 24'h400010);
  endtask

  task automatic t_byte_lanes;
    run(0, 0, 0, 24'h200033, 24'h000051, 16'h1234, 0);
    chk("R4", "byte busy 3+2", nbusy, 5);
    chk("R4", "odd lane lwr", {nhw[3:0], nlw[3:0]}, 8'h01);
    chk("R4", "odd lane data", fwd[7:0], 8'h34);
    run(0, 0, 0, 24'h200033, 24'h000050, 16'h1234, 0);
    chk("R4", "even lane hwr", {nhw[3:0], nlw[3:0]}, 8'h10);
    chk("R4", "even lane data", fwd[15:8], 8'h34);
  endtask

  task automatic t_single_read;
    run(1, 0, 1, 24'h200100, 24'h000000, 16'h0000, 0);
    chk("R5", "busy 3+3", nbusy, 6);
    chk("R5", "rd states", nrd, 4);
    chk("R5", "dack states", ndk, 4);
    chk("R5", "dack tracks as", dkmis, 0);
    chk("R5", "no write", nhw + nlw, 0);
    chk("R5", "addr first", frda, 24'h200100);
    chk("R5", "addr second", lrda, 24'h200101);
  endtask

  task automatic t_single_write;
    run(1, 1, 1, 24'h000000, 24'h400020, 16'h0000, 0);
    chk("R6", "busy", nbusy, 2);
    chk("R6", "strobes", {nhw[3:0], nlw[3:0]}, 8'h11);
    chk("R6", "dack", ndk, 1);
    chk("R6", "dack tracks as", dkmis, 0);
    chk("R6", "no read", nrd, 0);
    chk("R6", "addr", fwa, 24'h400020);
  endtask

  task automatic t_single_internal;
    run(1, 0, 1, 24'hFF8000, 24'h000000, 16'h0000, 0);
    chk("R8", "err pulse", nerr, 1);
    chk("R8", "no busy", nbusy, 0);
    chk("R8", "no strobe", nas, 0);
    chk("R8", "no done", ndone, 0);
  endtask

  task automatic t_dual_internal_src;
    run(0, 0, 1, 24'hFF0010, 24'h000300, 16'hBEEF, 0);
    chk("R7", "busy 2+2", nbusy, 4);
    chk("R7", "no read strobe", nrd, 0);
    chk("R7", "only write as", nas, 1);
    chk("R7", "addr zero", {a0, a1}, 48'h0);
    chk("R7", "data carried", fwd, 16'hBEEF);
  endtask

  task automatic t_restart_ignored;
    run(0, 0, 1, 24'h000100, 24'h400010, 16'h1111, 1);
    chk("R9", "busy unchanged", nbusy, 4);
    chk("R9", "single done", ndone, 1);
    chk("R9", "dest kept", fwa, 24'h400010);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dual_wide_to_narrow;
    t_dual_wide_to_wide;
    t_byte_lanes;
    t_single_read;
    t_single_write;
    t_single_internal;
    t_dual_internal_src;
    t_restart_ignored;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule